// File: doc/BRIEF.md
# Three-Multiplier Pipelined Complex Multiplier

This block multiplies a complex data sample x = A + jB by a complex weight w = C + jD, such as an FFT twiddle factor. It uses three real multipliers instead of four. Two pre-adders form A+B and C−D. The three multipliers produce the shared product (A+B)(C−D) and the cross terms BC and AD. Post-adders then rebuild the real part as (A+B)(C−D) − BC + AD and the imaginary part as BC + AD. That is three multiplies and five additions or subtractions per complex product.

All operands and results are W-bit two's complement fractions with one sign bit and W−1 fraction bits, so each covers [−1, 1−2^-(W−1)]. The full-precision results are brought back to W bits at the output. Truncation or round-half-up is chosen by a parameter, and there is no saturation.

The pipeline has three register stages: pre-add, multiply, post-add with scaling. Each stage loads only when the valid strobe travelling beside it is set.

Top module: `cmul3`

## Requirements
- R1: `y_im_o` equals the W-bit scaled value of BC + AD, where A=`x_re_i`, B=`x_im_i`, C=`w_re_i`, D=`w_im_i` are signed fractions with W−1 fraction bits.
- R2: `y_re_o` equals the W-bit scaled value of (A+B)(C−D) − BC + AD.
- R3: The pre-adders are one bit wider than the operands, so A+B and C−D are exact for every operand pair, including A=B=−1 and C=max, D=−1.
- R4: `valid_o` equals `valid_i` delayed by exactly 3 clock cycles, and the result for a sample appears in the same cycle as its `valid_o`.
- R5: While `valid_o` is low, `y_re_o` and `y_im_o` hold their last values.
- R6: With MODE = SCALE_TRUNC (0), the full-precision result (2W−2 fraction bits) is reduced by taking bits [2W−2:W−1]. This drops the duplicated sign bit and rounds toward minus infinity.
- R7: With MODE = SCALE_ROUND (1), 2^(W−2), half an output LSB, is added to the full-precision result before the same bit selection (round half up).
- R8: Results outside the output range wrap modulo 2^W with no saturation. For example, (−1)·(−1) = +1 appears as the most negative code.
- R9: While `rst_ni` is low, and until the first valid result, `valid_o` is 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand strobe |
| x_re_i | input | W | Sample real part A |
| x_im_i | input | W | Sample imaginary part B |
| w_re_i | input | W | Weight real part C |
| w_im_i | input | W | Weight imaginary part D |
| valid_o | output | 1 | Result strobe, 3 cycles after valid_i |
| y_re_o | output | W | Product real part |
| y_im_o | output | W | Product imaginary part |

## Verification
A 4-bit configuration is swept over every combination of the four operands. Two instances share the stimulus, one truncating and one rounding, so the two scaling rules are told apart on the same products. The operand sweep includes both extremes −1 and maximum positive on every input, which exposes a pre-adder that loses its carry or a missing wrap at +1. The input strobe has regular gaps, so the 3-cycle latency, the strobe alignment and the output hold during idle cycles are each checked against a model that tracks the last valid result.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
  typedef enum logic {
    SCALE_TRUNC = 1'b0,
    SCALE_ROUND = 1'b1
  } scale_mode_e;
endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
  parameter int W = 16,
  localparam int EW = W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [W-1:0]  a_i,
  input  logic signed [W-1:0]  b_i,
  input  logic signed [W-1:0]  c_i,
  input  logic signed [W-1:0]  d_i,
  output logic signed [EW-1:0] opl_o [3],
  output logic signed [EW-1:0] opr_o [3]
);
  logic signed [EW-1:0] ae, be, ce, de;
  assign ae = {a_i[W-1], a_i};
  assign be = {b_i[W-1], b_i};
  assign ce = {c_i[W-1], c_i};
  assign de = {d_i[W-1], d_i};

  // lane 0: shared product operands, lanes 1/2: cross terms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 3; k++) begin
        opl_o[k] <= '0;
        opr_o[k] <= '0;
      end
    end else if (en_i) begin
      opl_o[0] <= ae + be;
      opr_o[0] <= ce - de;
      opl_o[1] <= be;
      opr_o[1] <= ce;
      opl_o[2] <= ae;
      opr_o[2] <= de;
    end
  end
endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult #(
  parameter int EW = 17,
  localparam int PW = 2 * EW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [EW-1:0] l_i,
  input  logic signed [EW-1:0] r_i,
  output logic signed [PW-1:0] p_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_o <= '0;
    else if (en_i) p_o <= l_i * r_i;
  end
endmodule

// File: rtl/cmul3_post.sv
module cmul3_post
  import cmul3_pkg::*;
#(
  parameter int          W    = 16,
  parameter scale_mode_e MODE = SCALE_TRUNC,
  localparam int PW = 2 * (W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [PW-1:0] p_i [3],
  output logic        [W-1:0]  re_o,
  output logic        [W-1:0]  im_o
);
  localparam logic signed [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};
  localparam logic signed [PW-1:0] RND = (MODE == SCALE_ROUND) ? (ONE << (W - 2)) : '0;

  logic signed [PW-1:0] re_full, im_full, re_adj, im_adj;

  assign re_full = p_i[0] - p_i[1] + p_i[2];
  assign im_full = p_i[1] + p_i[2];
  assign re_adj  = re_full + RND;
  assign im_adj  = im_full + RND;

  // drop duplicated sign and W-1 low fraction bits; wraps on overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_o <= '0;
      im_o <= '0;
    end else if (en_i) begin
      re_o <= re_adj[2*W-2:W-1];
      im_o <= im_adj[2*W-2:W-1];
    end
  end
endmodule

// File: rtl/cmul3.sv
module cmul3
  import cmul3_pkg::*;
#(
  parameter int          W    = 16,
  parameter scale_mode_e MODE = SCALE_TRUNC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] x_re_i,
  input  logic [W-1:0] x_im_i,
  input  logic [W-1:0] w_re_i,
  input  logic [W-1:0] w_im_i,
  output logic         valid_o,
  output logic [W-1:0] y_re_o,
  output logic [W-1:0] y_im_o
);
  localparam int EW    = W + 1;
  localparam int PW    = 2 * EW;
  localparam int DEPTH = 3;

  logic [DEPTH-1:0]     vld_q;
  logic signed [EW-1:0] opl [3];
  logic signed [EW-1:0] opr [3];
  logic signed [PW-1:0] prod [3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[DEPTH-2:0], valid_i};
  end

  cmul3_preadd #(.W(W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .a_i   ($signed(x_re_i)),
    .b_i   ($signed(x_im_i)),
    .c_i   ($signed(w_re_i)),
    .d_i   ($signed(w_im_i)),
    .opl_o (opl),
    .opr_o (opr)
  );

  for (genvar g = 0; g < 3; g++) begin : g_mul
    cmul3_mult #(.EW(EW)) u_mul (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (vld_q[0]),
      .l_i   (opl[g]),
      .r_i   (opr[g]),
      .p_o   (prod[g])
    );
  end

  cmul3_post #(.W(W), .MODE(MODE)) u_post (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (vld_q[1]),
    .p_i   (prod),
    .re_o  (y_re_o),
    .im_o  (y_im_o)
  );

  assign valid_o = vld_q[DEPTH-1];
endmodule

// File: rtl/cmul3_chk.sv
module cmul3_chk
  import cmul3_pkg::*;
#(
  parameter int          W    = 16,
  parameter scale_mode_e MODE = SCALE_TRUNC
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] x_re_i,
  input logic [W-1:0] x_im_i,
  input logic [W-1:0] w_re_i,
  input logic [W-1:0] w_im_i,
  input logic         valid_o,
  input logic [W-1:0] y_re_o,
  input logic [W-1:0] y_im_o
);
  localparam int PW = 2 * (W + 1);
  localparam logic signed [PW-1:0] HALF =
    (MODE == SCALE_ROUND) ? ({{(PW-1){1'b0}}, 1'b1} << (W - 2)) : '0;

  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  // canonical four-product form, exact at full precision
  function automatic logic [W-1:0] ref_val(input logic signed [W-1:0] a, b, c, d,
                                           input logic im);
    logic signed [PW-1:0] t;
    t = im ? (a * d + b * c) : (a * c - b * d);
    t = t + HALF;
    return t[2*W-2:W-1];
  endfunction

  p_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 0) |-> (!valid_o && y_re_o == '0 && y_im_o == '0));

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 3) |-> (valid_o == $past(valid_i, 3)));

  p_real_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 3 && valid_o) |-> (y_re_o == ref_val($past(x_re_i, 3), $past(x_im_i, 3),
                                                 $past(w_re_i, 3), $past(w_im_i, 3), 1'b0)));

  p_imag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 3 && valid_o) |-> (y_im_o == ref_val($past(x_re_i, 3), $past(x_im_i, 3),
                                                 $past(w_re_i, 3), $past(w_im_i, 3), 1'b1)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 0 && !valid_o) |-> ($stable(y_re_o) && $stable(y_im_o)));
endmodule

bind cmul3 cmul3_chk #(.W(W), .MODE(MODE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .x_re_i (x_re_i),
  .x_im_i (x_im_i),
  .w_re_i (w_re_i),
  .w_im_i (w_im_i),
  .valid_o(valid_o),
  .y_re_o (y_re_o),
  .y_im_o (y_im_o)
);

// File: tb/cmul3_bench.sv
module cmul3_bench;
  import cmul3_pkg::*;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int NCMB = 1 << (4 * W);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] x_re_i = '0, x_im_i = '0, w_re_i = '0, w_im_i = '0;
  logic valid_t, valid_r;
  logic [W-1:0] re_t, im_t, re_r, im_r;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  cmul3 #(.W(W), .MODE(SCALE_TRUNC)) u_cmul3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .x_re_i(x_re_i), .x_im_i(x_im_i), .w_re_i(w_re_i), .w_im_i(w_im_i),
    .valid_o(valid_t), .y_re_o(re_t), .y_im_o(im_t)
  );

  cmul3 #(.W(W), .MODE(SCALE_ROUND)) u_cmul3_rnd (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .x_re_i(x_re_i), .x_im_i(x_im_i), .w_re_i(w_re_i), .w_im_i(w_im_i),
    .valid_o(valid_r), .y_re_o(re_r), .y_im_o(im_r)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int expv(input int a, b, c, d, input bit im, input bit rnd);
    int full;
    full = im ? (b * c + a * d) : ((a + b) * (c - d) - b * c + a * d);
    if (rnd) full += (1 << (W - 2));
    return (full >>> (W - 1)) & MASK;
  endfunction

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  // history of driven operands: slot 0 = last cycle, slot 2 = three cycles ago
  int  h_a[3], h_b[3], h_c[3], h_d[3];
  bit  h_v[3];
  int  last_re[2], last_im[2];

  task automatic check_outputs();
    int er, ei;
    bit corner;
    for (int m = 0; m < 2; m++) begin
      logic v;
      int ar, ai;
      string mt;
      v  = (m == 0) ? valid_t : valid_r;
      ar = int'((m == 0) ? re_t : re_r);
      ai = int'((m == 0) ? im_t : im_r);
      mt = (m == 0) ? "R6" : "R7";
      chk(v == h_v[2], "R4 valid_o alignment", int'(v), int'(h_v[2]));
      if (h_v[2]) begin
        corner = (h_a[2] == -8 || h_a[2] == 7) && (h_b[2] == -8 || h_b[2] == 7) &&
                 (h_c[2] == -8 || h_c[2] == 7) && (h_d[2] == -8 || h_d[2] == 7);
        er = expv(h_a[2], h_b[2], h_c[2], h_d[2], 1'b0, m == 1);
        ei = expv(h_a[2], h_b[2], h_c[2], h_d[2], 1'b1, m == 1);
        chk(ar == er, $sformatf("R2 %s%s real", mt, corner ? " R3 R8 corner" : ""), ar, er);
        chk(ai == ei, $sformatf("R1 %s%s imag", mt, corner ? " R3 R8 corner" : ""), ai, ei);
        last_re[m] = er;
        last_im[m] = ei;
      end else begin
        chk(ar == last_re[m], "R5 real hold", ar, last_re[m]);
        chk(ai == last_im[m], "R5 imag hold", ai, last_im[m]);
      end
    end
  endtask

  task automatic push(input bit v, input int a, b, c, d);
    for (int k = 2; k > 0; k--) begin
      h_a[k] = h_a[k-1]; h_b[k] = h_b[k-1]; h_c[k] = h_c[k-1];
      h_d[k] = h_d[k-1]; h_v[k] = h_v[k-1];
    end
    h_a[0] = a; h_b[0] = b; h_c[0] = c; h_d[0] = d; h_v[0] = v;
    valid_i = v;
    x_re_i = W'(a); x_im_i = W'(b); w_re_i = W'(c); w_im_i = W'(d);
  endtask

  initial begin
    int idx, cyc;
    for (int k = 0; k < 3; k++) begin
      h_v[k] = 0; h_a[k] = 0; h_b[k] = 0; h_c[k] = 0; h_d[k] = 0;
    end
    for (int m = 0; m < 2; m++) begin last_re[m] = 0; last_im[m] = 0; end
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(valid_t == 1'b0 && valid_r == 1'b0, "R9 valid_o in reset", int'(valid_t | valid_r), 0);
    chk(re_t == '0 && re_r == '0, "R9 real in reset", int'(re_t | re_r), 0);
    chk(im_t == '0 && im_r == '0, "R9 imag in reset", int'(im_t | im_r), 0);
    rst_ni = 1'b1;
    idx = 0;
    cyc = 0;
    while (idx < NCMB) begin
      @(negedge clk_i);
      check_outputs();
      if (cyc % 7 == 3) push(1'b0, 0, 0, 0, 0);
      else begin
        push(1'b1, sx(W'(idx)), sx(W'(idx >> W)), sx(W'(idx >> (2 * W))),
             sx(W'(idx >> (3 * W))));
        idx++;
      end
      cyc++;
    end
    repeat (4) begin
      @(negedge clk_i);
      check_outputs();
      push(1'b0, 0, 0, 0, 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule